// File: doc/BRIEF.md
# Instruction Decoder and Operand Addresser

This block turns one 8-bit opcode of a small accumulator / index-register processor into control fields for the rest of the core. It reads the opcode, the optional second instruction byte and the current index register. From these it produces the instruction class and the destination register. It also produces the operand source, a flag that asks the fetch logic for a second byte, and an illegal-instruction flag. For memory operands it also forms the effective address and picks the code or data region.

The decoded fields are registered, so they appear one clock after a valid opcode is presented. Cycles without a valid opcode produce an idle word: class NOP, no operand, every other field zero. Fetch sequencing, the memories, the ALU and the register file lie outside the block.

Top module: `instr_decoder`

## Requirements
- R1: While reset is active and on the first cycle after it, out_valid is 0, op_class is 0 (NOP), operand_src is 4 (none) and every other output is 0.
- R2: Outputs reflect the opcode presented one clock earlier. out_valid copies in_valid with one cycle of latency. A cycle with in_valid low yields the idle word described in R1.
- R3: The upper nibble selects the class for operand instructions. The codes are 0110 load=8, 0111 store=9, 1000 subtract-with-borrow=10, 1001 add-with-carry=11, 1010 subtract=12, 1011 add=13, 1100 xor=14, 1101 or=15, 1110 and=16, 1111 compare=17.
- R4: For operand and shift/rotate instructions, dest_is_index equals opcode bit 3 (0 accumulator, 1 index register). For all other classes it is 0.
- R5: For operand instructions, the opcode bits [2:0] set operand_src: 000 gives 0 (accumulator), 001 gives 1 (index), 01x gives 2 (immediate), 1xx gives 3 (memory). All other classes give 4 (none).
- R6: need_byte2 is 1 for immediate and memory operand modes and for every branch. Otherwise it is 0.
- R7: For memory modes, mode 10x gives eff_addr = byte2 and mode 11x gives eff_addr = (index_val + byte2) mod 256. data_region equals opcode bit 0, where 0 is the code region and 1 is the data region. For non-memory modes both outputs are 0.
- R8: Control opcodes map as follows: 00000xxx NOP=0, 00001xxx halt=1, 00010xxx output=2, 00011xxx input=3, 00100xxx clear-carry=4, 00101xxx set-carry=5. 0011cccc is branch=6 with branch_cond = cccc. branch_cond is 0 for every other class.
- R9: Opcodes 0101xxxx decode as halt (1) with illegal at 0.
- R10: 0100dsmm decodes as shift/rotate (7). is_rotate equals bit 2, shift_mode equals bits [1:0], operand_src is 4 and need_byte2 is 0.
- R11: A store (0111) with operand mode 0xx sets illegal to 1. In that case op_class is 0, operand_src is 4, and need_byte2, dest_is_index, eff_addr and data_region are 0. Stores with modes 1xx are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Instruction opcode byte |
| byte2 | input | ADDR_W | Second instruction byte |
| index_val | input | ADDR_W | Current index register value |
| out_valid | output | 1 | Decoded word is valid |
| op_class | output | 5 | Instruction class code |
| dest_is_index | output | 1 | Destination is the index register |
| operand_src | output | 3 | Operand source select |
| need_byte2 | output | 1 | Instruction needs a second byte |
| illegal | output | 1 | Illegal instruction |
| eff_addr | output | ADDR_W | Effective memory address |
| data_region | output | 1 | Memory operand is in the data region |
| branch_cond | output | 4 | Branch condition field |
| is_rotate | output | 1 | Rotate rather than shift |
| shift_mode | output | 2 | Shift/rotate mode field |

## Verification
Every decoded field passes through a single register stage. A wrong class, source or address therefore shows up on the ports exactly one clock after the offending opcode, and the next clean opcode overwrites it. Every opcode is swept against several byte2/index pairs, including pairs whose sum wraps past 255. This exposes mistakes in the upper-nibble mapping, the mode field, the region bit and the indexed adder at the first affected opcode. Idle cycles between opcodes show whether stale fields leak through when in_valid is low.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [4:0] {
        CL_NOP    = 5'd0,
        CL_HALT   = 5'd1,
        CL_OUT    = 5'd2,
        CL_IN     = 5'd3,
        CL_CLRC   = 5'd4,
        CL_SETC   = 5'd5,
        CL_BRANCH = 5'd6,
        CL_SHIFT  = 5'd7,
        CL_LOAD   = 5'd8,
        CL_STORE  = 5'd9,
        CL_SUBB   = 5'd10,
        CL_ADDC   = 5'd11,
        CL_SUB    = 5'd12,
        CL_ADD    = 5'd13,
        CL_XOR    = 5'd14,
        CL_OR     = 5'd15,
        CL_AND    = 5'd16,
        CL_CMP    = 5'd17
    } op_class_e;

    typedef enum logic [2:0] {
        SRC_ACC  = 3'd0,
        SRC_IDX  = 3'd1,
        SRC_IMM  = 3'd2,
        SRC_MEM  = 3'd3,
        SRC_NONE = 3'd4
    } src_sel_e;

    typedef struct packed {
        op_class_e  cls;
        logic       has_operand;
        logic       dest_ok;
        logic       bad_store;
        logic       is_branch;
        logic       is_shift;
    } class_info_t;

    typedef struct packed {
        src_sel_e   src;
        logic       need;
        logic       is_mem;
        logic       indexed;
        logic       region;
    } mode_info_t;

endpackage

// File: rtl/dec_class.sv
module dec_class
    import dec_pkg::*;
(
    input  logic [7:0]  opcode,
    output class_info_t info
);
    logic [3:0] hi_nib;
    assign hi_nib = opcode[7:4];

    always_comb begin
        info             = '0;
        info.cls         = CL_NOP;
        info.has_operand = (hi_nib[3:1] == 3'b011) || hi_nib[3];
        info.is_branch   = (hi_nib == 4'b0011);
        info.is_shift    = (hi_nib == 4'b0100);
        info.dest_ok     = info.has_operand || info.is_shift;
        info.bad_store   = (hi_nib == 4'b0111) && !opcode[2];
        unique case (hi_nib)
            4'b0000: info.cls = opcode[3] ? CL_HALT : CL_NOP;
            4'b0001: info.cls = opcode[3] ? CL_IN   : CL_OUT;
            4'b0010: info.cls = opcode[3] ? CL_SETC : CL_CLRC;
            4'b0011: info.cls = CL_BRANCH;
            4'b0100: info.cls = CL_SHIFT;
            4'b0101: info.cls = CL_HALT;
            4'b0110: info.cls = CL_LOAD;
            4'b0111: info.cls = CL_STORE;
            4'b1000: info.cls = CL_SUBB;
            4'b1001: info.cls = CL_ADDC;
            4'b1010: info.cls = CL_SUB;
            4'b1011: info.cls = CL_ADD;
            4'b1100: info.cls = CL_XOR;
            4'b1101: info.cls = CL_OR;
            4'b1110: info.cls = CL_AND;
            4'b1111: info.cls = CL_CMP;
            default: info.cls = CL_NOP;
        endcase
    end
endmodule

// File: rtl/dec_mode.sv
module dec_mode
    import dec_pkg::*;
(
    input  logic [2:0]  mode,
    output mode_info_t  info
);
    always_comb begin
        info         = '0;
        info.is_mem  = mode[2];
        info.indexed = mode[2] & mode[1];
        info.region  = mode[2] & mode[0];
        if (mode[2]) begin
            info.src  = SRC_MEM;
            info.need = 1'b1;
        end else if (mode[1]) begin
            info.src  = SRC_IMM;
            info.need = 1'b1;
        end else if (mode[0]) begin
            info.src  = SRC_IDX;
        end else begin
            info.src  = SRC_ACC;
        end
    end
endmodule

// File: rtl/dec_addr.sv
module dec_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              is_mem,
    input  logic              indexed,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] index_val,
    output logic [ADDR_W-1:0] eff
);
    logic [ADDR_W-1:0] carry;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] idx_term;

    assign idx_term = indexed ? index_val : '0;

    // ripple adder whose carry out of the top bit is dropped (mod 2^ADDR_W)
    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
            if (gi == 0) begin : g_lsb
                assign sum[gi]   = disp[gi] ^ idx_term[gi];
                assign carry[gi] = disp[gi] & idx_term[gi];
            end else begin : g_rest
                assign sum[gi]   = disp[gi] ^ idx_term[gi] ^ carry[gi-1];
                assign carry[gi] = (disp[gi] & idx_term[gi])
                                 | (carry[gi-1] & (disp[gi] ^ idx_term[gi]));
            end
        end
    endgenerate

    assign eff = is_mem ? sum : '0;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import dec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] byte2,
    input  logic [ADDR_W-1:0] index_val,
    output logic              out_valid,
    output logic [4:0]        op_class,
    output logic              dest_is_index,
    output logic [2:0]        operand_src,
    output logic              need_byte2,
    output logic              illegal,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              data_region,
    output logic [3:0]        branch_cond,
    output logic              is_rotate,
    output logic [1:0]        shift_mode
);
    typedef struct packed {
        logic              valid;
        op_class_e         cls;
        logic              dest;
        src_sel_e          src;
        logic              need;
        logic              bad;
        logic [ADDR_W-1:0] eff;
        logic              region;
        logic [3:0]        cond;
        logic              rot;
        logic [1:0]        smode;
    } dec_out_t;

    localparam dec_out_t IDLE = '{
        valid: 1'b0, cls: CL_NOP, dest: 1'b0, src: SRC_NONE, need: 1'b0,
        bad: 1'b0, eff: '0, region: 1'b0, cond: 4'd0, rot: 1'b0, smode: 2'd0
    };

    class_info_t       cls_info;
    mode_info_t        mode_info;
    logic [ADDR_W-1:0] eff_raw;
    dec_out_t          out_d, out_q;

    dec_class i_dec_class (
        .opcode (opcode),
        .info   (cls_info)
    );

    dec_mode i_dec_mode (
        .mode (opcode[2:0]),
        .info (mode_info)
    );

    dec_addr #(.ADDR_W(ADDR_W)) i_dec_addr (
        .is_mem    (mode_info.is_mem),
        .indexed   (mode_info.indexed),
        .disp      (byte2),
        .index_val (index_val),
        .eff       (eff_raw)
    );

    always_comb begin
        out_d = IDLE;
        if (in_valid) begin
            out_d.valid = 1'b1;
            if (cls_info.bad_store) begin
                out_d.bad = 1'b1;
            end else begin
                out_d.cls  = cls_info.cls;
                out_d.dest = cls_info.dest_ok & opcode[3];
                if (cls_info.has_operand) begin
                    out_d.src    = mode_info.src;
                    out_d.need   = mode_info.need;
                    out_d.eff    = eff_raw;
                    out_d.region = mode_info.region;
                end
                if (cls_info.is_branch) begin
                    out_d.need = 1'b1;
                    out_d.cond = opcode[3:0];
                end
                if (cls_info.is_shift) begin
                    out_d.rot   = opcode[2];
                    out_d.smode = opcode[1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= IDLE;
        else        out_q <= out_d;
    end

    assign out_valid     = out_q.valid;
    assign op_class      = out_q.cls;
    assign dest_is_index = out_q.dest;
    assign operand_src   = out_q.src;
    assign need_byte2    = out_q.need;
    assign illegal       = out_q.bad;
    assign eff_addr      = out_q.eff;
    assign data_region   = out_q.region;
    assign branch_cond   = out_q.cond;
    assign is_rotate     = out_q.rot;
    assign shift_mode    = out_q.smode;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [ADDR_W-1:0] byte2,
    input logic [ADDR_W-1:0] index_val,
    input logic              out_valid,
    input logic [4:0]        op_class,
    input logic              dest_is_index,
    input logic [2:0]        operand_src,
    input logic              need_byte2,
    input logic              illegal,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              data_region,
    input logic [3:0]        branch_cond,
    input logic              is_rotate,
    input logic [1:0]        shift_mode
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && op_class == 5'd0 && operand_src == 3'd4));

    // R11
    illegal_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (op_class == 5'd0 && !need_byte2 && operand_src == 3'd4 && eff_addr == '0));

    // R6
    branch_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 5'd6) |-> need_byte2);

    // R7
    nonmem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_src != 3'd3) |-> (eff_addr == '0 && !data_region));

    // R7
    indexed_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:1] == 2'b11 && (opcode[7] || opcode[7:4] == 4'b0110
            || opcode[7:4] == 4'b0111))
        |=> (eff_addr == ADDR_W'($past(index_val) + $past(byte2))));

    // R9
    unused_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] == 4'b0101) |=> (op_class == 5'd1 && !illegal));

    // R4
    ctrl_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class < 5'd7) |-> !dest_is_index);
endmodule

bind instr_decoder instr_decoder_chk #(.ADDR_W(ADDR_W)) i_instr_decoder_chk (.*);

// File: tb/test_instr_decoder.sv
`timescale 1ns/1ps
module test_instr_decoder;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   opcode = '0;
    logic [W-1:0] byte2 = '0;
    logic [W-1:0] index_val = '0;
    logic         out_valid;
    logic [4:0]   op_class;
    logic         dest_is_index;
    logic [2:0]   operand_src;
    logic         need_byte2;
    logic         illegal;
    logic [W-1:0] eff_addr;
    logic         data_region;
    logic [3:0]   branch_cond;
    logic         is_rotate;
    logic [1:0]   shift_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    instr_decoder #(.ADDR_W(W)) i_instr_decoder (.*);

    typedef struct packed {
        logic [4:0]   cls;
        logic         dest;
        logic [2:0]   src;
        logic         need;
        logic         bad;
        logic [W-1:0] eff;
        logic         reg_d;
        logic [3:0]   cond;
        logic         rot;
        logic [1:0]   sm;
    } exp_t;

    exp_t sb_q[$];

    function automatic exp_t idle_word();
        exp_t e = '0;
        e.src = 3'd4;
        return e;
    endfunction

    // expected fields built from the requirement text
    function automatic exp_t model(input logic [7:0] op, input logic [W-1:0] b2,
                                   input logic [W-1:0] ix);
        exp_t e = idle_word();
        logic [3:0] hi = op[7:4];
        if (hi == 4'h7 && op[2] == 1'b0) begin   // R11
            e.bad = 1'b1;
            return e;
        end
        case (hi)                                // R8, R9, R3
            4'h0: e.cls = op[3] ? 5'd1 : 5'd0;
            4'h1: e.cls = op[3] ? 5'd3 : 5'd2;
            4'h2: e.cls = op[3] ? 5'd5 : 5'd4;
            4'h3: begin e.cls = 5'd6; e.cond = op[3:0]; e.need = 1'b1; end
            4'h4: begin e.cls = 5'd7; e.rot = op[2]; e.sm = op[1:0]; e.dest = op[3]; end
            4'h5: e.cls = 5'd1;
            default: e.cls = 5'(hi) + 5'd2;
        endcase
        if (hi >= 4'h6) begin
            e.dest = op[3];
            if (op[2:0] == 3'b000)      e.src = 3'd0;
            else if (op[2:0] == 3'b001) e.src = 3'd1;
            else if (op[2] == 1'b0)     begin e.src = 3'd2; e.need = 1'b1; end
            else begin
                e.src   = 3'd3;
                e.need  = 1'b1;
                e.reg_d = op[0];
                e.eff   = op[1] ? W'(int'(b2) + int'(ix)) : b2;
            end
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (opcode in flight)", req, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R3/R8", "op_class",     op_class,      e.cls);
        chk("R4",    "dest",         dest_is_index, e.dest);
        chk("R5",    "operand_src",  operand_src,   e.src);
        chk("R6",    "need_byte2",   need_byte2,    e.need);
        chk("R11",   "illegal",      illegal,       e.bad);
        chk("R7",    "eff_addr",     eff_addr,      e.eff);
        chk("R7",    "data_region",  data_region,   e.reg_d);
        chk("R8",    "branch_cond",  branch_cond,   e.cond);
        chk("R10",   "is_rotate",    is_rotate,     e.rot);
        chk("R10",   "shift_mode",   shift_mode,    e.sm);
    endtask

    task automatic drive(input logic [7:0] op, input logic [W-1:0] b2, input logic [W-1:0] ix);
        @(negedge clk);
        in_valid  = 1'b1;
        opcode    = op;
        byte2     = b2;
        index_val = ix;
        sb_q.push_back(model(op, b2, ix));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        opcode   = 8'hA5;
        byte2    = 8'h5A;
    endtask

    // monitor: one register stage, sample 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) chk("R2", "unexpected out_valid", 1, 0);
                else compare(sb_q.pop_front());
            end else begin
                // R2 idle word when nothing was presented
                chk("R2", "idle op_class", op_class, 0);
                chk("R2", "idle operand_src", operand_src, 4);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "op_class", op_class, 0);
        chk("R1", "operand_src", operand_src, 4);
        chk("R1", "eff_addr", eff_addr, 0);
        chk("R1", "need_byte2", need_byte2, 0);
        rst_n = 1'b1;
        idle();
        // directed corners: R9 unused space, R11 bad stores, R7 wraparound
        drive(8'h5C, 8'h10, 8'h20);
        drive(8'h72, 8'h33, 8'h44);
        drive(8'h7F, 8'hF0, 8'h20);
        drive(8'h6E, 8'hFF, 8'h01);
        idle();
        drive(8'h3E, 8'h80, 8'h00);
        drive(8'h4D, 8'h00, 8'h00);
        // exhaustive sweep with several operand patterns
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 256; o++) begin
                case (p)
                    0: drive(8'(o), 8'h12, 8'h34);
                    1: drive(8'(o), 8'hC0, 8'h7F);
                    default: drive(8'(o), 8'(o), 8'(255 - o + p));
                endcase
                if ((o % 37) == 0) idle();
            end
        end
        idle();
        repeat (3) @(negedge clk);
        chk("R2", "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule